// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Condition Codes

This block is a purely combinational arithmetic-logic unit. It takes two operands of a configurable width, a single carry input and a 3-bit operation code. It returns a result of the same width and a 4-bit condition-code vector. The unit performs five bitwise operations, an add that includes the carry input, a two's-complement subtract, and a signed set-on-less-than compare.

A datapath places it between its operand sources and its result sink. The condition codes are meant to be captured next to the result. They give the sign, the zero test, signed overflow and the carry out of the adder. There are no registers inside the block, so any change on an input reaches both outputs within the same cycle.

Top module: `alu_cc`

## Requirements
- R1: Logical operations by op code: 000 gives A AND B, 001 gives A OR B, 011 gives A XOR B, 100 gives NOT(A OR B), 101 gives NOT(A AND B).
- R2: Op code 010 adds. The result is the low W bits of A + B + carry-in, and the carry flag (bit 0 of the flag vector) is bit W of that sum.
- R3: For add, the overflow flag (bit 1) is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R4: Op code 110 subtracts. The result is A + NOT(B) + 1 taken modulo 2^W. The carry flag is 1 exactly when A >= B compared as unsigned numbers. The carry-in input has no effect on result or flags.
- R5: For subtract, the overflow flag is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R6: Op code 111 sets result bit 0 to 1 when A < B compared as signed numbers, including the cases where A - B overflows. All other result bits are 0.
- R7: For every operation, flag bit 3 equals result bit W-1 (negative), and flag bit 2 is 1 exactly when the whole result is zero.
- R8: For the five logical operations and for set-on-less-than, the overflow flag and the carry flag are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| cin | input | 1 | Carry input, used only by add |
| op_sel | input | 3 | Operation code |
| cond_flags | output | 4 | {negative, zero, overflow, carry}, from MSB to LSB |
| result | output | W | Operation result |

## Verification
The block holds no state, so any internal fault shows up at the ports on the same input vector that exercises it, and there is no lag after the stimulus. A wrong carry link in the ripple chain corrupts the sum bits above the faulty stage and the carry flag. A wrong operand-inversion or carry-in choice shifts a subtract result by one, or flips the unsigned-compare carry. A bad overflow tap misreports signed overflow and also inverts the set-on-less-than answer at the signed boundary operands. Directed vectors therefore aim at the sign-boundary and all-ones cases, and mixed operand patterns back them up.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_XOR  = 3'b011,
        OP_NOR  = 3'b100,
        OP_NAND = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cout;
    } cc_t;

    localparam int CC_W = $bits(cc_t);

    function automatic logic uses_adder(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic invert_b(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic reports_carry(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] c;

    assign c[0] = c0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        logic g;
        assign p        = a[i] ^ b[i];
        assign g        = a[i] & b[i];
        assign sum[i]   = p ^ c[i];
        assign c[i+1]   = g | (p & c[i]);
    end

    assign cout = c[W];
    assign ovf  = c[W] ^ c[W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_NAND: y = ~(a & b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         arith_ovf,
    input  logic         arith_cout,
    input  logic         arith_valid,
    output cc_t          cc
);
    always_comb begin
        cc.neg  = res[W-1];
        cc.zero = ~|res;
        cc.ovf  = arith_valid & arith_ovf;
        cc.cout = arith_valid & arith_cout;
    end
endmodule

// File: rtl/alu_cc.sv
module alu_cc
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              cin,
    input  logic [2:0]        op_sel,
    output logic [CC_W-1:0]   cond_flags,
    output logic [W-1:0]      result
);
    localparam logic [W-1:0] ZERO_W = '0;

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic         c_first;
    logic [W-1:0] sum;
    logic         sum_cout;
    logic         sum_ovf;
    logic [W-1:0] logic_y;
    logic         less;
    cc_t          cc;

    assign op      = alu_op_e'(op_sel);
    assign b_eff   = invert_b(op) ? ~opb : opb;
    assign c_first = invert_b(op) ? 1'b1 : cin;

    alu_carry_chain #(.W(W)) u_chain (
        .a    (opa),
        .b    (b_eff),
        .c0   (c_first),
        .sum  (sum),
        .cout (sum_cout),
        .ovf  (sum_ovf)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a  (opa),
        .b  (opb),
        .op (op),
        .y  (logic_y)
    );

    assign less = sum[W-1] ^ sum_ovf;

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: result = sum;
            OP_SLT:         result = {ZERO_W[W-1:1], less};
            default:        result = logic_y;
        endcase
    end

    alu_flag_pack #(.W(W)) u_flags (
        .res         (result),
        .arith_ovf   (sum_ovf),
        .arith_cout  (sum_cout),
        .arith_valid (reports_carry(op)),
        .cc          (cc)
    );

    assign cond_flags = cc;

    always_comb begin
        if (op == OP_ADD) begin
            // R2
            add_sum_chk: assert ({cond_flags[0], result} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin}))
                else $error("add sum or carry mismatch");
            // R3
            add_ovf_chk: assert (cond_flags[1] == ((opa[W-1] == opb[W-1]) && (result[W-1] != opa[W-1])))
                else $error("add overflow mismatch");
        end
        if (op == OP_SUB) begin
            // R4
            sub_carry_chk: assert ((cond_flags[0] == (opa >= opb)) && (result == opa - opb))
                else $error("subtract carry or result mismatch");
        end
        if (op == OP_SLT) begin
            // R6
            slt_value_chk: assert (result == {ZERO_W[W-1:1], ($signed(opa) < $signed(opb))})
                else $error("set-less-than mismatch");
        end
        if (!uses_adder(op) || op == OP_SLT) begin
            // R8
            no_arith_flags_chk: assert (cond_flags[1:0] == 2'b00)
                else $error("carry or overflow set on non-arithmetic op");
        end
    end
endmodule

// File: tb/alu_cc_test.sv
module alu_cc_test;
    localparam int W = 32;
    localparam logic [W-1:0] MAXU = '1;
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic [3:0]   cond_flags;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    alu_cc #(.W(W)) uut (
        .opa        (opa),
        .opb        (opb),
        .cin        (cin),
        .op_sel     (op_sel),
        .cond_flags (cond_flags),
        .result     (result)
    );

    task automatic apply(input string tag, input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c);
        logic [W:0]   wide;
        logic [W-1:0] er;
        logic         ev, ec;
        @(negedge clk);
        op_sel = op; opa = a; opb = b; cin = c;
        #2;
        ev = 1'b0; ec = 1'b0; er = '0;
        case (op)
            3'b000: er = a & b;
            3'b001: er = a | b;
            3'b011: er = a ^ b;
            3'b100: er = ~(a | b);
            3'b101: er = ~(a & b);
            3'b010: begin
                wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
                er = wide[W-1:0]; ec = wide[W];
                ev = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]);
            end
            3'b110: begin
                er = a - b; ec = (a >= b);
                ev = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]);
            end
            default: er = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
        checks++;
        if (result !== er) begin
            fails++;
            $display("FAIL %s op=%b result actual=%h expected=%h", tag, op, result, er);
        end
        checks++;
        if (cond_flags !== {er[W-1], (er == '0), ev, ec}) begin
            fails++;
            $display("FAIL %s op=%b flags actual=%b expected=%b", tag, op, cond_flags,
                     {er[W-1], (er == '0), ev, ec});
        end
    endtask

    task automatic test_idle_state;
        apply("R7_idle", 3'b000, '0, '0, 1'b0);
    endtask

    task automatic test_logic_ops;
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] b = $urandom;
            apply("R1_and",  3'b000, a, b, i[0]);
            apply("R1_or",   3'b001, a, b, i[0]);
            apply("R1_xor",  3'b011, a, b, i[0]);
            apply("R1_nor",  3'b100, a, b, i[0]);
            apply("R1_nand", 3'b101, a, b, i[0]);
        end
        apply("R8_nand_ones", 3'b101, '0, '0, 1'b1);
        apply("R8_xor_eq", 3'b011, MAXU, MAXU, 1'b1);
    endtask

    task automatic test_add;
        apply("R2_wrap", 3'b010, MAXU, 32'd1, 1'b0);
        apply("R2_cin_wrap", 3'b010, MAXU, '0, 1'b1);
        apply("R2_cin_chain", 3'b010, MAXU, MAXU, 1'b1);
        apply("R3_pos_ovf", 3'b010, MAXP, 32'd1, 1'b0);
        apply("R3_neg_ovf", 3'b010, MINN, MINN, 1'b0);
        apply("R3_cin_ovf", 3'b010, MAXP, '0, 1'b1);
        for (int i = 0; i < 40; i++) apply("R2_rand", 3'b010, $urandom, $urandom, i[1]);
    endtask

    task automatic test_sub;
        apply("R4_equal", 3'b110, 32'd77, 32'd77, 1'b0);
        apply("R4_borrow", 3'b110, 32'd3, 32'd5, 1'b0);
        apply("R4_cin_ignored", 3'b110, 32'd3, 32'd5, 1'b1);
        apply("R4_zero_minus_zero_cin", 3'b110, '0, '0, 1'b1);
        apply("R5_ovf_pos", 3'b110, MAXP, MAXU, 1'b0);
        apply("R5_ovf_neg", 3'b110, MINN, 32'd1, 1'b1);
        for (int i = 0; i < 40; i++) apply("R4_rand", 3'b110, $urandom, $urandom, i[0]);
    endtask

    task automatic test_slt;
        apply("R6_lt", 3'b111, 32'd2, 32'd9, 1'b0);
        apply("R6_ge", 3'b111, 32'd9, 32'd2, 1'b1);
        apply("R6_eq", 3'b111, MAXU, MAXU, 1'b0);
        apply("R6_ovf_true", 3'b111, MINN, 32'd1, 1'b0);
        apply("R6_ovf_false", 3'b111, MAXP, MAXU, 1'b0);
        apply("R6_neg_pos", 3'b111, MAXU, '0, 1'b1);
        for (int i = 0; i < 40; i++) apply("R6_rand", 3'b111, $urandom, $urandom, i[0]);
    endtask

    task automatic test_flags;
        apply("R7_neg_or", 3'b001, MINN, '0, 1'b0);
        apply("R7_zero_add", 3'b010, MINN, MINN, 1'b0);
        apply("R7_zero_and", 3'b000, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_idle_state();
        test_logic_ops();
        test_add();
        test_sub();
        test_slt();
        test_flags();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule